// File: doc/BRIEF.md
# PHY High-Speed Timing Configuration Sequencer

This block turns a requested lane bit rate and a set of high-speed timing values into an ordered run of eight register writes toward a PHY test-port master. A single `start` pulse captures the rate, a manual-timing flag and seven timing values. The block then looks up the frequency-range code for the rate and writes it. After that it writes the seven timing override codes, with a programmable wait between consecutive timing writes.

Each write is offered to the master as a one-cycle `wr_start` pulse. An 8-bit code and an 8-bit data value are held steady until the master answers with `wr_done`. A one-cycle `done` pulse marks the end of the run. While a run is in progress, a new `start` has no effect. When the manual flag is clear, all seven timing codes are still written, each with data zero. This clears any earlier overrides.

Top module: `hs_timing_seq`

## Requirements
- R1: The first write of a run uses code 0x44. Its data carries the range code in bits 6:1, with bits 7 and 0 zero. The range code comes from the first row, in ascending order of threshold, whose maximum rate in Mbps is at or above the captured rate. Examples: a rate of 90 or less gives 0x00, 91 to 100 gives 0x10, 101 to 110 gives 0x20, 111 to 130 gives 0x01, 951 to 1000 gives 0x1a and 1201 to 1250 gives 0x2b. The table has 39 rows.
- R2: A rate above 1500 gives the last row's code, 0x3c.
- R3: The range write is followed by seven timing writes in this order: 0x71 data prepare, 0x72 data zero, 0x73 data trail, 0x61 clock prepare, 0x62 clock zero, 0x63 clock trail, 0x65 clock post.
- R4: With the manual flag set, the data fields are as follows.
  - Prepare and trail writes carry the 7-bit value in bits 6:0, with bit 7 set.
  - Zero writes carry the 6-bit value in bits 5:0, with bit 6 set and bit 7 clear.
  - The post write carries the 5-bit value in bits 4:0, with bit 5 set and bits 7:6 clear.
- R5: With the manual flag clear, all seven timing writes carry data 0x00.
- R6: Timing write spacing is fixed.
  - Each timing write after the first has its `wr_start` exactly WAIT_CYCLES+1 cycles after the cycle in which the previous timing write's `wr_done` was seen.
  - The first timing write starts the cycle after the range write's `wr_done`.
- R7: After reset, `busy`, `done` and `wr_start` are low. A `start` seen while idle raises `wr_start` and `busy` in the next cycle. `busy` stays high through the cycle of the final `wr_done`.
- R8: `done` is a one-cycle pulse in the cycle after the final `wr_done`, and `busy` is low in that cycle.
- R9: A `start` while `busy` is high changes no write and does not restart the run. A `start` in the `done` cycle is accepted.
- R10: Write handshake rules:
  - `wr_start` is high for exactly one cycle per write.
  - `wr_code` and `wr_data` hold steady from that cycle until `wr_done` is seen.
  - A `wr_done` that arrives while no write is outstanding is ignored.
- R11: The rate, flag and timing values are captured at the accepted `start`. Later changes to them do not affect the run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (ignored while busy) |
| rate_mbps | input | RATE_W | Requested lane bit rate in Mbps |
| manual | input | 1 | Write manual timing overrides when set |
| dat_prep | input | 7 | Data-lane prepare value |
| dat_zero | input | 6 | Data-lane zero value |
| dat_trail | input | 7 | Data-lane trail value |
| ck_prep | input | 7 | Clock-lane prepare value |
| ck_zero | input | 6 | Clock-lane zero value |
| ck_trail | input | 7 | Clock-lane trail value |
| ck_post | input | 5 | Clock-lane post value |
| wr_start | output | 1 | One-cycle request for a test-port write |
| wr_code | output | 8 | Test code of the current write |
| wr_data | output | 8 | Data of the current write |
| wr_done | input | 1 | Master reports the current write finished |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
Two events can coincide at the end of a run: a new `start` request and the completion of the final write.

The bench holds `start` high across an entire run. The request therefore arrives during the final `wr_done` cycle, where it must be ignored. It also arrives in the following `done` cycle, where it must launch a second run.

A cycle-level model accepts or rejects each request from its own idea of the busy state. That model is judged clock by clock on `busy`, `done`, the `wr_start` position, and the code and data of every write. It must show exactly two back-to-back runs with no duplicated or dropped write.

// File: rtl/hs_timing_seq.sv
module hs_timing_seq #(
  parameter int RATE_W      = 12,
  parameter int WAIT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] rate_mbps,
  input  logic              manual,
  input  logic [6:0]        dat_prep,
  input  logic [5:0]        dat_zero,
  input  logic [6:0]        dat_trail,
  input  logic [6:0]        ck_prep,
  input  logic [5:0]        ck_zero,
  input  logic [6:0]        ck_trail,
  input  logic [4:0]        ck_post,
  output logic              wr_start,
  output logic [7:0]        wr_code,
  output logic [7:0]        wr_data,
  input  logic              wr_done,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam int NROWS = 39;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_ACK, S_PAUSE} state_t;

  state_t           state;
  logic [2:0]       step;
  logic [CNT_W-1:0] cnt;
  logic             done_q, man_q;
  logic [5:0]       range_q, dz_q, cz_q;
  logic [6:0]       dp_q, dt_q, cp_q, ct_q;
  logic [4:0]       cpo_q;

  // {max rate (11 bits), range code (6 bits)}
  function automatic logic [16:0] row(input int i);
    case (i)
      0:  row = {11'd90,   6'h00}; 1:  row = {11'd100,  6'h10};
      2:  row = {11'd110,  6'h20}; 3:  row = {11'd130,  6'h01};
      4:  row = {11'd140,  6'h11}; 5:  row = {11'd150,  6'h21};
      6:  row = {11'd170,  6'h02}; 7:  row = {11'd180,  6'h12};
      8:  row = {11'd200,  6'h22}; 9:  row = {11'd220,  6'h03};
      10: row = {11'd240,  6'h13}; 11: row = {11'd250,  6'h23};
      12: row = {11'd270,  6'h04}; 13: row = {11'd300,  6'h14};
      14: row = {11'd330,  6'h05}; 15: row = {11'd360,  6'h15};
      16: row = {11'd400,  6'h25}; 17: row = {11'd450,  6'h06};
      18: row = {11'd500,  6'h16}; 19: row = {11'd550,  6'h07};
      20: row = {11'd600,  6'h17}; 21: row = {11'd650,  6'h08};
      22: row = {11'd700,  6'h18}; 23: row = {11'd750,  6'h09};
      24: row = {11'd800,  6'h19}; 25: row = {11'd850,  6'h29};
      26: row = {11'd900,  6'h39}; 27: row = {11'd950,  6'h0a};
      28: row = {11'd1000, 6'h1a}; 29: row = {11'd1050, 6'h2a};
      30: row = {11'd1100, 6'h3a}; 31: row = {11'd1150, 6'h0b};
      32: row = {11'd1200, 6'h1b}; 33: row = {11'd1250, 6'h2b};
      34: row = {11'd1300, 6'h3b}; 35: row = {11'd1350, 6'h0c};
      36: row = {11'd1400, 6'h1c}; 37: row = {11'd1450, 6'h2c};
      default: row = {11'd1500, 6'h3c};
    endcase
  endfunction

  function automatic logic [5:0] range_of(input logic [RATE_W-1:0] r);
    logic [16:0] e;
    range_of = 6'h3c;
    for (int i = NROWS - 1; i >= 0; i--) begin
      e = row(i);
      if (32'(r) <= 32'(e[16:6])) range_of = e[5:0];
    end
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; step <= '0; cnt <= '0; done_q <= 1'b0;
      man_q <= 1'b0; range_q <= '0;
      dp_q <= '0; dz_q <= '0; dt_q <= '0;
      cp_q <= '0; cz_q <= '0; ct_q <= '0; cpo_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          range_q <= range_of(rate_mbps);
          man_q <= manual;
          dp_q <= dat_prep; dz_q <= dat_zero; dt_q <= dat_trail;
          cp_q <= ck_prep;  cz_q <= ck_zero;  ct_q <= ck_trail; cpo_q <= ck_post;
          step  <= '0;
          state <= S_REQ;
        end
        S_REQ: state <= S_ACK;
        S_ACK: if (wr_done) begin
          if (step == 3'd7) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            step <= step + 3'd1;
            if (step == 3'd0) state <= S_REQ;
            else begin
              cnt   <= CNT_LOAD;
              state <= S_PAUSE;
            end
          end
        end
        S_PAUSE: if (cnt == '0) state <= S_REQ;
                 else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (step)
      3'd0:    begin wr_code = 8'h44; wr_data = {1'b0, range_q, 1'b0}; end
      3'd1:    begin wr_code = 8'h71; wr_data = man_q ? {1'b1, dp_q} : 8'h00; end
      3'd2:    begin wr_code = 8'h72; wr_data = man_q ? {2'b01, dz_q} : 8'h00; end
      3'd3:    begin wr_code = 8'h73; wr_data = man_q ? {1'b1, dt_q} : 8'h00; end
      3'd4:    begin wr_code = 8'h61; wr_data = man_q ? {1'b1, cp_q} : 8'h00; end
      3'd5:    begin wr_code = 8'h62; wr_data = man_q ? {2'b01, cz_q} : 8'h00; end
      3'd6:    begin wr_code = 8'h63; wr_data = man_q ? {1'b1, ct_q} : 8'h00; end
      default: begin wr_code = 8'h65; wr_data = man_q ? {3'b001, cpo_q} : 8'h00; end
    endcase
  end

  assign wr_start = (state == S_REQ);
  assign busy     = (state != S_IDLE);
  assign done     = done_q;

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state == S_ACK && wr_done));
  // R10
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);
  // R10
  hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACK) |-> ($stable(wr_code) && $stable(wr_data)));
  // R6
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PAUSE && cnt != '0) |=> (state == S_PAUSE));
  // R9
  busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != S_ACK) |=> busy);
endmodule

// File: tb/hs_timing_seq_test.sv
module hs_timing_seq_test;
  localparam int RATE_W = 12;
  localparam int WAITC  = 64;

  logic clk = 0, rst_n = 0, start = 0, manual = 0, wr_done = 0;
  logic [RATE_W-1:0] rate_mbps = '0;
  logic [6:0] dat_prep = 0, dat_trail = 0, ck_prep = 0, ck_trail = 0;
  logic [5:0] dat_zero = 0, ck_zero = 0;
  logic [4:0] ck_post = 0;
  logic wr_start, busy, done;
  logic [7:0] wr_code, wr_data;

  int checks = 0, fails = 0, cycles = 0;

  hs_timing_seq #(.RATE_W(RATE_W), .WAIT_CYCLES(WAITC)) uut (
    .clk, .rst_n, .start, .rate_mbps, .manual,
    .dat_prep, .dat_zero, .dat_trail, .ck_prep, .ck_zero, .ck_trail, .ck_post,
    .wr_start, .wr_code, .wr_data, .wr_done, .busy, .done);

  always #2.5 clk = ~clk;

  int thr [39] = '{90,100,110,130,140,150,170,180,200,220,240,250,270,300,330,
                   360,400,450,500,550,600,650,700,750,800,850,900,950,1000,
                   1050,1100,1150,1200,1250,1300,1350,1400,1450,1500};
  int rcode [39] = '{'h00,'h10,'h20,'h01,'h11,'h21,'h02,'h12,'h22,'h03,'h13,
                     'h23,'h04,'h14,'h05,'h15,'h25,'h06,'h16,'h07,'h17,'h08,
                     'h18,'h09,'h19,'h29,'h39,'h0a,'h1a,'h2a,'h3a,'h0b,'h1b,
                     'h2b,'h3b,'h0c,'h1c,'h2c,'h3c};

  function automatic int range_ref(input int r);
    for (int i = 0; i < 39; i++) if (r <= thr[i]) return rcode[i];
    return 'h3c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // reference model state
  int q_code[$], q_data[$];
  bit m_busy = 0, m_done = 0, m_wait = 0;
  int m_gap = -1, m_idx = 0, h_code = 0, h_data = 0, writes_seen = 0;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R7 busy", busy, m_busy);
      chk("R8 done", done, m_done);
      chk("R6/R10 wr_start timing", wr_start, m_gap == 0);
      if (m_wait && !wr_start) begin
        chk("R10 code hold", wr_code, h_code);
        chk("R10 data hold", wr_data, h_data);
      end
      if (wr_start) begin
        writes_seen++;
        if (q_code.size() == 0) chk("R9 unexpected write", 1, 0);
        else begin
          chk((m_idx == 0) ? "R1/R2 range write code" : "R3 timing code order", wr_code, q_code.pop_front());
          chk((m_idx == 0) ? "R1/R2 range write data" : "R4/R5 timing data", wr_data, q_data.pop_front());
        end
        h_code = wr_code; h_data = wr_data;
        m_wait = 1; m_gap = -1;
      end
      m_done = 0;
      if (m_gap > 0) m_gap--;
      if (!m_busy && start) begin
        int b[7];
        b[0] = manual ? (128 | dat_prep) : 0;
        b[1] = manual ? (64 | dat_zero) : 0;
        b[2] = manual ? (128 | dat_trail) : 0;
        b[3] = manual ? (128 | ck_prep) : 0;
        b[4] = manual ? (64 | ck_zero) : 0;
        b[5] = manual ? (128 | ck_trail) : 0;
        b[6] = manual ? (32 | ck_post) : 0;
        q_code.push_back('h44); q_data.push_back(range_ref(int'(rate_mbps)) << 1);
        q_code.push_back('h71); q_data.push_back(b[0]);
        q_code.push_back('h72); q_data.push_back(b[1]);
        q_code.push_back('h73); q_data.push_back(b[2]);
        q_code.push_back('h61); q_data.push_back(b[3]);
        q_code.push_back('h62); q_data.push_back(b[4]);
        q_code.push_back('h63); q_data.push_back(b[5]);
        q_code.push_back('h65); q_data.push_back(b[6]);
        m_busy = 1; m_gap = 0; m_idx = 0;
      end else if (m_wait && wr_done && !wr_start) begin
        m_wait = 0; m_idx++;
        if (m_idx == 8) begin m_busy = 0; m_done = 1; end
        else if (m_idx == 1) m_gap = 0;
        else m_gap = WAITC;
      end
    end
  end

  // test-port master model with rotating latency
  int lat_cnt = 0, lat_sel = 0;
  bit stray_done = 0;
  always begin
    @(posedge clk); #1;
    wr_done = stray_done;
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) wr_done = 1;
    end else if (wr_start) begin
      lat_cnt = 1 + (lat_sel % 4);
      lat_sel++;
    end
  end

  task automatic set_in(input int r, input bit m, input int dp, dz, dt, cp, cz, ct, cpo);
    rate_mbps = RATE_W'(r); manual = m;
    dat_prep = 7'(dp); dat_zero = 6'(dz); dat_trail = 7'(dt);
    ck_prep = 7'(cp); ck_zero = 6'(cz); ck_trail = 7'(ct); ck_post = 5'(cpo);
  endtask

  task automatic run_one();
    @(posedge clk); #1; start = 1;
    @(posedge clk); #1; start = 0;
    while (busy) begin @(posedge clk); #1; end
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset busy", busy, 0);
    chk("R7 reset done", done, 0);
    chk("R7 reset wr_start", wr_start, 0);
    rst_n = 1;

    set_in(85, 0, 5, 5, 5, 5, 5, 5, 5);       run_one();   // R1 first row, R5
    set_in(90, 1, 7'h55, 6'h2a, 7'h11, 7'h22, 6'h3f, 7'h7f, 5'h1f); run_one(); // R1 boundary, R4
    set_in(91, 1, 0, 0, 0, 0, 0, 0, 0);       run_one();   // R1, R4 zero values
    set_in(1000, 1, 1, 2, 3, 4, 5, 6, 7);     run_one();   // R1
    set_in(1250, 0, 9, 9, 9, 9, 9, 9, 9);     run_one();   // R1, R5
    set_in(1501, 1, 3, 3, 3, 3, 3, 3, 3);     run_one();   // R2
    set_in(4000, 0, 0, 0, 0, 0, 0, 0, 0);     run_one();   // R2

    // R9/R11: restart attempts and input changes mid-run, plus stray done while idle (R10)
    stray_done = 1; repeat (3) @(posedge clk); #1; stray_done = 0;
    @(posedge clk); #1;
    chk("R10 stray done ignored", busy, 0);
    set_in(120, 1, 10, 11, 12, 13, 14, 15, 16);
    @(posedge clk); #1; start = 1;
    @(posedge clk); #1; start = 0;
    repeat (30) @(posedge clk);
    #1;
    start = 1; set_in(1400, 0, 0, 0, 0, 0, 0, 0, 0);
    @(posedge clk); #1; start = 0;
    while (busy) begin @(posedge clk); #1; end
    repeat (2) @(posedge clk);
    #1;

    // R9: start held across a run end: ignored at the final wr_done, accepted in the done cycle
    writes_seen = 0;
    set_in(330, 1, 1, 1, 1, 1, 1, 1, 1);
    @(posedge clk); #1; start = 1;
    while (!done) begin @(posedge clk); #1; end
    @(posedge clk); #1; start = 0;
    while (busy) begin @(posedge clk); #1; end
    repeat (3) @(posedge clk);
    #1;
    chk("R9 two back-to-back runs", writes_seen, 16);
    chk("R9 queue drained", q_code.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule